// File: doc/BRIEF.md
# Per-core store buffer with total store ordering

The block sits between one processor core's load/store port and a shared memory that has separate write and read ports. Each accepted store goes into a small circular queue. The queue drains to the memory write port in the order the stores were issued, one entry per accepted handshake. Other agents can see a buffered store only after it has left the queue.

Loads do not wait behind buffered stores. A load first searches the queue by address. If any entry matches, the load completes in the same cycle with the data of the youngest matching entry. If nothing matches, the load goes straight to the memory read port, even when older stores to other addresses are still queued. Write-to-read order is therefore relaxed, while write-to-write order is kept.

A fence request holds back every later load until the queue is completely empty. The core uses it where full sequential ordering is needed. When the queue is full, the store port is back-pressured.

Top module: `tso_store_buffer`

## Requirements
- R1: After reset the queue is empty: `st_ready_o` is 1, and `mw_valid_o`, `mr_valid_o` and `ld_rvalid_o` are 0.
- R2: A store is accepted in a cycle where `st_valid_i` and `st_ready_o` are both 1. `st_ready_o` is 0 while DEPTH entries are held.
- R3: Stores appear on the memory write port in the order they were accepted. While `mw_ready_i` is 0, the presented address and data stay stable. An entry leaves only on a cycle with `mw_valid_o` and `mw_ready_i` both 1, and at most one entry leaves per cycle.
- R4: While the queue holds any entry, `mw_valid_o` is 1. With `mw_ready_i` held at 1, a full queue is empty after DEPTH cycles.
- R5: When a load address matches a queued entry, `ld_ready_o` and `ld_rvalid_o` are 1 in the same cycle as `ld_valid_i`. `ld_rdata_o` carries the data of the youngest matching entry, and no memory read is issued.
- R6: When a load address matches no entry, `mr_valid_o` is raised with `mr_addr_o` equal to the load address in that cycle, even if older stores to other addresses are still queued. The load is accepted when `mr_ready_i` is 1. `ld_rvalid_o` then returns `mr_rdata_i` in the cycle `mr_rvalid_i` is 1.
- R7: After `fence_i` is 1 in a cycle, later loads see `ld_ready_o` = 0 and `mr_valid_o` = 0 until the queue is empty.
- R8: When a store and a load are presented in the same cycle, the load counts as the older access and does not see that store.
- R9: Only one memory read is outstanding at a time. While a read is waiting for its response, `ld_ready_o` and `mr_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| st_valid_i | input | 1 | Store request |
| st_addr_i | input | ADDR_W | Store address |
| st_data_i | input | DATA_W | Store data |
| st_ready_o | output | 1 | Queue can accept a store |
| ld_valid_i | input | 1 | Load request |
| ld_addr_i | input | ADDR_W | Load address |
| ld_ready_o | output | 1 | Load accepted |
| ld_rvalid_o | output | 1 | Load data valid |
| ld_rdata_o | output | DATA_W | Load data |
| fence_i | input | 1 | Stall later loads until the queue is empty |
| mw_valid_o | output | 1 | Memory write request (queue head) |
| mw_addr_o | output | ADDR_W | Memory write address |
| mw_data_o | output | DATA_W | Memory write data |
| mw_ready_i | input | 1 | Memory accepts the write |
| mr_valid_o | output | 1 | Memory read request |
| mr_addr_o | output | ADDR_W | Memory read address |
| mr_ready_i | input | 1 | Memory accepts the read |
| mr_rvalid_i | input | 1 | Memory read data valid |
| mr_rdata_i | input | DATA_W | Memory read data |

## Verification
Most results are combinational from the current queue state. A forwarded load is due in the cycle it is presented. The queue head, `st_ready_o` and a miss request reflect a store or pop one clock after its handshake. A missed load completes in the cycle the read response arrives. The bench drives inputs just after the rising edge and samples every output at the falling edge, so it always compares within the cycle the result is due. Forwarded loads are also checked to complete in their first sampled cycle. A scoreboard queue of accepted stores is compared against each write handshake as it happens. Fence and reordering checks inspect the scoreboard depth at the moment the load completes.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic {
    LD_IDLE = 1'b0,
    LD_WAIT = 1'b1
  } ld_state_e;
endpackage

// File: rtl/sb_fifo.sv
module sb_fifo #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic              vld_o  [DEPTH],
  output logic [ADDR_W-1:0] addr_o [DEPTH],
  output logic [DATA_W-1:0] data_o [DEPTH],
  output logic [PTR_W-1:0]  head_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              vld_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= ptr_inc(tail_q);
      if (pop_i)  head_q <= ptr_inc(head_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + CNT_W'(1);
      else if (pop_i && !push_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        addr_q[g] <= '0;
        data_q[g] <= '0;
      end else begin
        if (push_i && tail_q == PTR_W'(g)) begin
          vld_q[g]  <= 1'b1;
          addr_q[g] <= push_addr_i;
          data_q[g] <= push_data_i;
        end else if (pop_i && head_q == PTR_W'(g)) begin
          vld_q[g] <= 1'b0;
        end
      end
    end
    assign vld_o[g]  = vld_q[g];
    assign addr_o[g] = addr_q[g];
    assign data_o[g] = data_q[g];
  end

  assign head_o  = head_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q != CNT_W'(DEPTH))); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> vld_q[head_q]); // R3
  AST_HEAD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |=> $stable(head_q)); // R3
endmodule

// File: rtl/sb_fwd.sv
module sb_fwd #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              vld_i  [DEPTH],
  input  logic [ADDR_W-1:0] addr_i [DEPTH],
  input  logic [DATA_W-1:0] data_i [DEPTH],
  input  logic [PTR_W-1:0]  head_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] data_o
);
  // Walk oldest to youngest; later matches override earlier ones.
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = int'(head_i) + k;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if (vld_i[idx] && addr_i[idx] == ld_addr_i) begin
        hit_o  = 1'b1;
        data_o = data_i[idx];
      end
    end
  end
endmodule

// File: rtl/sb_load_ctrl.sv
module sb_load_ctrl
  import sb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic              block_i,
  input  logic              hit_i,
  input  logic [DATA_W-1:0] fwd_data_i,
  output logic              ld_ready_o,
  output logic              ld_rvalid_o,
  output logic [DATA_W-1:0] ld_rdata_o,
  output logic              mr_valid_o,
  output logic [ADDR_W-1:0] mr_addr_o,
  input  logic              mr_ready_i,
  input  logic              mr_rvalid_i,
  input  logic [DATA_W-1:0] mr_rdata_i
);
  ld_state_e state_q, state_d;
  logic      go;

  assign go        = ld_valid_i && !block_i;
  assign mr_addr_o = ld_addr_i;

  always_comb begin
    state_d     = state_q;
    ld_ready_o  = 1'b0;
    ld_rvalid_o = 1'b0;
    ld_rdata_o  = '0;
    mr_valid_o  = 1'b0;
    unique case (state_q)
      LD_IDLE: begin
        if (go && hit_i) begin
          ld_ready_o  = 1'b1;
          ld_rvalid_o = 1'b1;
          ld_rdata_o  = fwd_data_i;
        end else if (go) begin
          mr_valid_o = 1'b1;
          ld_ready_o = mr_ready_i;
          if (mr_ready_i) state_d = LD_WAIT;
        end
      end
      LD_WAIT: begin
        ld_rvalid_o = mr_rvalid_i;
        ld_rdata_o  = mr_rdata_i;
        if (mr_rvalid_i) state_d = LD_IDLE;
      end
      default: state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LD_IDLE;
    else         state_q <= state_d;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mr_valid_o && mr_ready_i) |=> (!mr_valid_o && !ld_ready_o)); // R9
  AST_WAIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LD_WAIT && !mr_rvalid_i) |=> !mr_valid_o); // R9
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  output logic              st_ready_o,
  input  logic              ld_valid_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic              ld_ready_o,
  output logic              ld_rvalid_o,
  output logic [DATA_W-1:0] ld_rdata_o,
  input  logic              fence_i,
  output logic              mw_valid_o,
  output logic [ADDR_W-1:0] mw_addr_o,
  output logic [DATA_W-1:0] mw_data_o,
  input  logic              mw_ready_i,
  output logic              mr_valid_o,
  output logic [ADDR_W-1:0] mr_addr_o,
  input  logic              mr_ready_i,
  input  logic              mr_rvalid_i,
  input  logic [DATA_W-1:0] mr_rdata_i
);
  logic              vld  [DEPTH];
  logic [ADDR_W-1:0] addr [DEPTH];
  logic [DATA_W-1:0] data [DEPTH];
  logic [PTR_W-1:0]  head;
  logic              full, empty, push, pop;
  logic              hit, fence_pend_q, ld_block;
  logic [DATA_W-1:0] fwd_data;

  assign st_ready_o = !full;
  assign push       = st_valid_i && !full;
  assign mw_valid_o = !empty;
  assign mw_addr_o  = addr[head];
  assign mw_data_o  = data[head];
  assign pop        = mw_valid_o && mw_ready_i;

  sb_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .push_addr_i(st_addr_i), .push_data_i(st_data_i),
    .pop_i(pop),
    .vld_o(vld), .addr_o(addr), .data_o(data),
    .head_o(head), .full_o(full), .empty_o(empty)
  );

  sb_fwd #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
    .vld_i(vld), .addr_i(addr), .data_i(data), .head_i(head),
    .ld_addr_i(ld_addr_i), .hit_o(hit), .data_o(fwd_data)
  );

  // Fence stays armed until the queue has been seen empty.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fence_pend_q <= 1'b0;
    else         fence_pend_q <= (fence_pend_q || fence_i) && !empty;
  end
  assign ld_block = (fence_pend_q || fence_i) && !empty;

  sb_load_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ld (
    .clk_i, .rst_ni,
    .ld_valid_i, .ld_addr_i, .block_i(ld_block),
    .hit_i(hit), .fwd_data_i(fwd_data),
    .ld_ready_o, .ld_rvalid_o, .ld_rdata_o,
    .mr_valid_o, .mr_addr_o, .mr_ready_i, .mr_rvalid_i, .mr_rdata_i
  );

  AST_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mw_valid_o && !mw_ready_i) |=> (mw_valid_o && $stable(mw_addr_o) && $stable(mw_data_o))); // R3
  AST_FULL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!st_ready_o && mw_ready_i) |=> st_ready_o); // R4
  AST_FWD_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_rvalid_o && ld_ready_o) |-> !mr_valid_o); // R5
  AST_FENCE_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fence_i) && !empty) |-> (!ld_ready_o && !mr_valid_o)); // R7
endmodule

// File: tb/sim_tso_store_buffer.sv
module sim_tso_store_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4, AW = 16, DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, ld_valid = 0, fence = 0, mw_rdy = 0, mr_rvalid = 0;
  logic mr_rdy = 1'b1;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0, mr_rdata = '0;
  logic st_ready, ld_ready, ld_rvalid, mw_valid, mr_valid;
  logic [DW-1:0] ld_rdata, mw_data;
  logic [AW-1:0] mw_addr, mr_addr;

  int errors = 0, checks = 0;
  logic [AW+DW-1:0] exp_q[$];
  logic [DW-1:0] mem [logic [AW-1:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  tso_store_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data), .st_ready_o(st_ready),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr), .ld_ready_o(ld_ready),
    .ld_rvalid_o(ld_rvalid), .ld_rdata_o(ld_rdata), .fence_i(fence),
    .mw_valid_o(mw_valid), .mw_addr_o(mw_addr), .mw_data_o(mw_data), .mw_ready_i(mw_rdy),
    .mr_valid_o(mr_valid), .mr_addr_o(mr_addr), .mr_ready_i(mr_rdy),
    .mr_rvalid_i(mr_rvalid), .mr_rdata_i(mr_rdata)
  );

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    return mem.exists(a) ? mem[a] : {16'hA5A5, a};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: write handshakes against the scoreboard, plus hold stability.
  logic hold_seen = 0;
  logic [AW+DW-1:0] hold_val;
  always @(negedge clk) if (rst_n) begin
    if (hold_seen)
      check({mw_valid, mw_addr, mw_data} == {1'b1, hold_val}, "R3 hold", {mw_addr, mw_data}, hold_val);
    hold_seen = mw_valid && !mw_rdy;
    hold_val  = {mw_addr, mw_data};
    if (mw_valid && mw_rdy) begin
      if (exp_q.size() == 0) check(0, "R3 unexpected write", {mw_addr, mw_data}, 0);
      else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        check({mw_addr, mw_data} == e, "R3 order", {mw_addr, mw_data}, e);
        mem[mw_addr] = mw_data;
      end
    end
  end

  // Memory read responder: data one idle cycle after acceptance.
  initial forever begin
    @(posedge clk);
    if (rst_n && mr_valid && mr_rdy) begin
      logic [AW-1:0] a;
      a = mr_addr;
      @(posedge clk); #1 mr_rvalid = 1; mr_rdata = mem_rd(a);
      @(posedge clk); #1 mr_rvalid = 0;
    end
  end

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #1 st_valid = 1; st_addr = a; st_data = d;
    forever begin @(negedge clk); if (st_ready) break; end
    exp_q.push_back({a, d});
    @(posedge clk); #1 st_valid = 0;
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [DW-1:0] exp, input bit fwd,
                         input bit need_empty, input bit need_pending, input string tag);
    int cyc = 0;
    bit hs = 0;
    @(posedge clk); #1 ld_valid = 1; ld_addr = a;
    forever begin
      @(negedge clk); cyc++;
      if (ld_rvalid && (fwd || hs)) begin
        check(ld_rdata == exp, tag, ld_rdata, exp);
        if (fwd) check(cyc == 1 && ld_ready && !mr_valid, "R5 same-cycle forward", cyc, 1);
        if (need_empty) check(exp_q.size() == 0, "R7 load after drain", exp_q.size(), 0);
        if (need_pending) check(exp_q.size() > 0, "R6 overtakes stores", exp_q.size(), 1);
        break;
      end else if (hs) begin
        check(!ld_ready && !mr_valid, "R9 single outstanding", {ld_ready, mr_valid}, 0);
      end else if (ld_ready && mr_valid && mr_rdy) begin
        check(mr_addr == a && !fwd, "R6 read address", mr_addr, a);
        hs = 1;
      end
    end
    @(posedge clk); #1 ld_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(st_ready && !mw_valid && !mr_valid && !ld_rvalid, "R1 reset state",
          {st_ready, mw_valid, mr_valid, ld_rvalid}, 4'b1000);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    check(st_ready && !mw_valid && !mr_valid && !ld_rvalid, "R1 after reset",
          {st_ready, mw_valid, mr_valid, ld_rvalid}, 4'b1000);

    // Fill and stall; forward from a mid entry.
    mw_rdy = 0;
    for (int i = 0; i < DEPTH; i++) do_store(AW'(16'h10 + i), DW'(32'h100 + i));
    @(negedge clk);
    check(!st_ready, "R2 full back-pressure", st_ready, 0);
    check(mw_valid && mw_addr == 16'h10, "R3 head first", mw_addr, 16'h10);
    do_load(16'h12, 32'h102, 1, 0, 0, "R5 forward data");
    @(posedge clk); #1 mw_rdy = 1;
    repeat (DEPTH + 1) @(negedge clk);
    check(exp_q.size() == 0 && !mw_valid && st_ready, "R4 drained", exp_q.size(), 0);

    // Youngest match and a load overtaking queued stores.
    @(posedge clk); #1 mw_rdy = 0;
    do_store(16'h20, 32'h1);
    do_store(16'h21, 32'h5);
    do_store(16'h20, 32'h2);
    do_load(16'h20, 32'h2, 1, 0, 0, "R5 youngest match");
    do_load(16'h30, mem_rd(16'h30), 0, 0, 1, "R6 miss data");
    @(posedge clk); #1 mw_rdy = 1;
    repeat (DEPTH + 1) @(negedge clk);
    check(exp_q.size() == 0, "R4 drained again", exp_q.size(), 0);

    // Same-cycle store and load to one address.
    @(posedge clk); #1 mw_rdy = 0;
    begin
      logic [DW-1:0] old40;
      old40 = mem_rd(16'h40);
      fork
        do_store(16'h40, 32'h77);
        do_load(16'h40, old40, 0, 0, 0, "R8 load older than store");
      join
    end
    @(posedge clk); #1 mw_rdy = 1;
    repeat (3) @(negedge clk);
    do_load(16'h40, 32'h77, 0, 0, 0, "R6 read after drain");

    // Fence.
    @(posedge clk); #1 mw_rdy = 0;
    do_store(16'h50, 32'h11);
    do_store(16'h51, 32'h22);
    @(posedge clk); #1 fence = 1;
    @(posedge clk); #1 fence = 0;
    fork
      do_load(16'h60, mem_rd(16'h60), 0, 1, 0, "R7 fenced load data");
      begin
        repeat (3) @(negedge clk);
        check(!ld_ready && !mr_valid, "R7 stalled", {ld_ready, mr_valid}, 0);
        @(posedge clk); #1 mw_rdy = 1;
      end
    join

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule